// File: doc/BRIEF.md
# Stop Mode Power Controller

This block puts a small processor subsystem into its deepest power state and brings it back out. The CPU requests the state by writing two control bits: a power-save mode select and a stop bit. Once both are set, the controller lets a fixed number of instruction slots pass with the CPU still clocked. It then turns off the main oscillator and gates the clocks to the CPU and to main-clock peripherals. The controller runs on the always-running subclock, so peripherals clocked from the subclock or from an external clock keep working.

Any non-maskable request, any unmasked external or peripheral interrupt line, or a reset ends the stop state. The controller re-enables the oscillator and keeps the CPU clock gated while a down-counter, loaded from a programmable count, covers the oscillator settling time. Waking and acknowledging are separate decisions. Every unmasked source wakes the block. The resume code then tells the CPU either to branch to the handler, which acknowledges the request, or to continue at the next instruction, which leaves the request pending. That choice depends on the global interrupt enable and on how the request's priority compares with the one in service.

Top module: `stop_ctrl`

## Requirements
- R1: Stop is entered only from normal running, and only when both the mode-select bit and the stop bit read 1. `in_stop` first reads 1 exactly ENTRY_DELAY+1 clock edges after the edge that stores the write (default 6). The CPU clock stays enabled in between.
- R2: While `in_stop` is 1, `osc_en`, `cpu_clk_en` and `per_clk_en` are all 0. In every other state `osc_en` is 1.
- R3: The wake sources are `nmi_req`, `ext_req[i]` where `ext_mask[i]`=0, and `per_req[j]` where `per_mask[j]`=0. A mask bit of 1 means masked. Masked requests leave the block in stop.
- R4: The edge that ends stop raises `wake_pulse` for one cycle. The CPU clock stays off for stab_count+1 edges counted from that edge. `ready_pulse` then reads 1 for one cycle, and the CPU and peripheral clocks come back on at the same edge.
- R5: Any wake source ends stop at the next edge, whatever its priority.
- R6: `resume_kind` encodes the action: 0 = reset vector, 1 = branch to the handler (request acknowledged), 2 = continue at the next instruction (request left pending). It is updated at the wake edge and holds until the next wake. A non-maskable wake always gives 1.
- R7: A maskable wake gives 1 only when `int_en`=1 and either `isr_active`=0 or `pend_lvl` < `isr_lvl`. A smaller level number means a higher priority. In every other case it gives 2, including equal levels and `int_en`=0.
- R8: A wake source that appears during the entry window returns the block to running. The stop bit is cleared and stop is never entered.
- R9: The stop bit reads 0 after every release, and the block does not enter stop again until the CPU writes the stop bit again.
- R10: Reset, from any state, clears both control bits, sets `resume_kind` to 0, turns the oscillator on, and holds the CPU clock off for stab_count+1 edges after the last reset edge. `ready_pulse` follows at the end of that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Subclock, always running |
| rst | input | 1 | Synchronous active-high reset, also a wake source |
| wr_en | input | 1 | CPU write strobe for the control bits |
| wr_psmode | input | 1 | Value written to the power-save mode-select bit |
| wr_stop | input | 1 | Value written to the stop bit |
| nmi_req | input | 1 | Non-maskable interrupt request |
| ext_req | input | N_EXT | External interrupt lines |
| ext_mask | input | N_EXT | External line masks, 1 = masked |
| per_req | input | N_PER | Interrupt lines from peripherals that run in stop |
| per_mask | input | N_PER | Peripheral line masks, 1 = masked |
| pend_lvl | input | LVL_W | Priority level of the highest pending maskable request |
| isr_active | input | 1 | A handler is in service |
| isr_lvl | input | LVL_W | Priority level of the handler in service |
| int_en | input | 1 | Global interrupt enable |
| stab_count | input | CNT_W | Oscillator settling count |
| osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Main-clock peripheral gate enable |
| psmode_bit | output | 1 | Current mode-select bit |
| stop_bit | output | 1 | Current stop bit |
| in_stop | output | 1 | Block is in the stop state |
| wake_pulse | output | 1 | One-cycle pulse when stop ends |
| ready_pulse | output | 1 | One-cycle pulse when settling ends |
| resume_kind | output | 2 | Resume action code |

## Verification
The assertions assume three things about the inputs. The CPU issues no control write while it is stopped or settling. The priority inputs carry meaningful values whenever a maskable request wakes the block. A request that is held is not interpreted as a new write. The stimulus writes only while the block is running. It sets the levels, enables and masks one cycle before it raises a request, and it drops every request right after `wake_pulse`. Between scenarios all lines are masked, so each wake has exactly one intended source.

// File: rtl/stopc_pkg.sv
package stopc_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_ARM  = 2'd1,
        ST_STOP = 2'd2,
        ST_WARM = 2'd3
    } pstate_e;

    typedef enum logic [1:0] {
        RK_RESET   = 2'd0,
        RK_HANDLER = 2'd1,
        RK_NEXT    = 2'd2
    } resume_e;

    typedef struct packed {
        logic mode_sel;
        logic stop;
    } ctl_t;

    // Resume action for a wake: non-maskable always branches; a maskable
    // request branches only when enabled and outranking the service level.
    function automatic resume_e pick_resume(input logic nmi,
                                            input logic ie,
                                            input logic outranks);
        if (nmi)
            return RK_HANDLER;
        else if (ie && outranks)
            return RK_HANDLER;
        else
            return RK_NEXT;
    endfunction

endpackage

// File: rtl/stopc_downcnt.sv
module stopc_downcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] count,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (load)
            cnt_q <= load_val;
        else if (dec && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    assign count = cnt_q;
    assign zero  = (cnt_q == '0);
endmodule

// File: rtl/stopc_wake.sv
module stopc_wake
    import stopc_pkg::*;
#(
    parameter int N_EXT = 7,
    parameter int N_PER = 4,
    parameter int LVL_W = 3
) (
    input  logic             nmi_req,
    input  logic [N_EXT-1:0] ext_req,
    input  logic [N_EXT-1:0] ext_mask,
    input  logic [N_PER-1:0] per_req,
    input  logic [N_PER-1:0] per_mask,
    input  logic             int_en,
    input  logic             isr_active,
    input  logic [LVL_W-1:0] pend_lvl,
    input  logic [LVL_W-1:0] isr_lvl,
    output logic             wake,
    output resume_e          kind
);
    logic [N_EXT-1:0] ext_live;
    logic [N_PER-1:0] per_live;
    logic             outranks;

    genvar gi;
    generate
        for (gi = 0; gi < N_EXT; gi++) begin : g_ext
            assign ext_live[gi] = ext_req[gi] & ~ext_mask[gi];
        end
        for (gi = 0; gi < N_PER; gi++) begin : g_per
            assign per_live[gi] = per_req[gi] & ~per_mask[gi];
        end
    endgenerate

    assign outranks = !isr_active || (pend_lvl < isr_lvl);
    assign wake     = nmi_req || (|ext_live) || (|per_live);
    assign kind     = pick_resume(nmi_req, int_en, outranks);
endmodule

// File: rtl/stop_ctrl.sv
module stop_ctrl
    import stopc_pkg::*;
#(
    parameter int N_EXT       = 7,
    parameter int N_PER       = 4,
    parameter int LVL_W       = 3,
    parameter int CNT_W       = 16,
    parameter int ENTRY_DELAY = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_psmode,
    input  logic             wr_stop,
    input  logic             nmi_req,
    input  logic [N_EXT-1:0] ext_req,
    input  logic [N_EXT-1:0] ext_mask,
    input  logic [N_PER-1:0] per_req,
    input  logic [N_PER-1:0] per_mask,
    input  logic [LVL_W-1:0] pend_lvl,
    input  logic             isr_active,
    input  logic [LVL_W-1:0] isr_lvl,
    input  logic             int_en,
    input  logic [CNT_W-1:0] stab_count,
    output logic             osc_en,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             psmode_bit,
    output logic             stop_bit,
    output logic             in_stop,
    output logic             wake_pulse,
    output logic             ready_pulse,
    output logic [1:0]       resume_kind
);
    localparam int AW = (ENTRY_DELAY < 2) ? 1 : $clog2(ENTRY_DELAY);
    localparam logic [AW-1:0] ARM_LOAD = AW'(ENTRY_DELAY - 1);

    pstate_e st_q;
    ctl_t    ctl_q;
    resume_e kind_q;
    logic    wake_pulse_q, ready_q;

    logic    wake;
    resume_e wake_kind;

    logic          arm_zero;
    logic [AW-1:0] arm_cnt;
    logic          stab_zero;
    logic [CNT_W-1:0] stab_cnt;

    stopc_wake #(.N_EXT(N_EXT), .N_PER(N_PER), .LVL_W(LVL_W)) u_wake (
        .nmi_req   (nmi_req),
        .ext_req   (ext_req),
        .ext_mask  (ext_mask),
        .per_req   (per_req),
        .per_mask  (per_mask),
        .int_en    (int_en),
        .isr_active(isr_active),
        .pend_lvl  (pend_lvl),
        .isr_lvl   (isr_lvl),
        .wake      (wake),
        .kind      (wake_kind)
    );

    // Entry window: reloaded every running cycle, counts while armed.
    stopc_downcnt #(.W(AW)) u_arm_cnt (
        .clk     (clk),
        .load    (rst || (st_q == ST_RUN)),
        .load_val(ARM_LOAD),
        .dec     (st_q == ST_ARM),
        .count   (arm_cnt),
        .zero    (arm_zero)
    );

    // Settling window: loaded by reset or by the wake edge.
    stopc_downcnt #(.W(CNT_W)) u_stab_cnt (
        .clk     (clk),
        .load    (rst || ((st_q == ST_STOP) && wake)),
        .load_val(stab_count),
        .dec     (st_q == ST_WARM),
        .count   (stab_cnt),
        .zero    (stab_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= ST_WARM;
            ctl_q        <= '0;
            kind_q       <= RK_RESET;
            wake_pulse_q <= 1'b0;
            ready_q      <= 1'b0;
        end else begin
            wake_pulse_q <= 1'b0;
            ready_q      <= 1'b0;
            if (wr_en)
                ctl_q <= '{mode_sel: wr_psmode, stop: wr_stop};
            unique case (st_q)
                ST_RUN: begin
                    if (ctl_q.mode_sel && ctl_q.stop)
                        st_q <= ST_ARM;
                end
                ST_ARM: begin
                    if (wake) begin
                        st_q       <= ST_RUN;
                        ctl_q.stop <= 1'b0;
                    end else if (arm_zero) begin
                        st_q <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (wake) begin
                        st_q         <= ST_WARM;
                        ctl_q.stop   <= 1'b0;
                        kind_q       <= wake_kind;
                        wake_pulse_q <= 1'b1;
                    end
                end
                ST_WARM: begin
                    if (stab_zero) begin
                        st_q    <= ST_RUN;
                        ready_q <= 1'b1;
                    end
                end
                default: st_q <= ST_RUN;
            endcase
        end
    end

    logic clk_on;
    assign clk_on      = (st_q == ST_RUN) || (st_q == ST_ARM);
    assign osc_en      = (st_q != ST_STOP);
    assign cpu_clk_en  = clk_on;
    assign per_clk_en  = clk_on;
    assign in_stop     = (st_q == ST_STOP);
    assign psmode_bit  = ctl_q.mode_sel;
    assign stop_bit    = ctl_q.stop;
    assign wake_pulse  = wake_pulse_q;
    assign ready_pulse = ready_q;
    assign resume_kind = kind_q;

    logic unused_cnt;
    assign unused_cnt = ^{arm_cnt, stab_cnt};
endmodule

// File: rtl/stop_ctrl_chk.sv
module stop_ctrl_chk #(
    parameter int N_EXT = 7,
    parameter int N_PER = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             nmi_req,
    input logic [N_EXT-1:0] ext_req,
    input logic [N_EXT-1:0] ext_mask,
    input logic [N_PER-1:0] per_req,
    input logic [N_PER-1:0] per_mask,
    input logic             osc_en,
    input logic             cpu_clk_en,
    input logic             per_clk_en,
    input logic             psmode_bit,
    input logic             stop_bit,
    input logic             in_stop,
    input logic             wake_pulse,
    input logic             ready_pulse,
    input logic [1:0]       resume_kind
);
    logic nmi_prev, nmi_woke;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_prev <= 1'b0;
            nmi_woke <= 1'b0;
        end else begin
            nmi_prev <= nmi_req;
            if (wake_pulse)
                nmi_woke <= nmi_prev;
        end
    end

    AST_ENTRY_GUARD: assert property (@(posedge clk) disable iff (rst)
        $rose(in_stop) |-> $past(stop_bit) && $past(psmode_bit) && $past(cpu_clk_en)); // R1
    AST_STOP_CLOCKS_OFF: assert property (@(posedge clk) disable iff (rst)
        in_stop |-> !osc_en && !cpu_clk_en && !per_clk_en); // R2
    AST_MASKED_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
        in_stop && !nmi_req && ((ext_req & ~ext_mask) == '0) && ((per_req & ~per_mask) == '0)
        |=> in_stop); // R3
    AST_CPU_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk_en) |-> ready_pulse); // R4
    AST_NMI_RELEASES: assert property (@(posedge clk) disable iff (rst)
        in_stop && nmi_req |=> !in_stop && wake_pulse); // R5
    AST_NMI_BRANCHES: assert property (@(posedge clk) disable iff (rst)
        ready_pulse && nmi_woke |-> resume_kind == 2'd1); // R6
    AST_STOP_BIT_CLEARED: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> !stop_bit); // R9
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !cpu_clk_en && osc_en && !stop_bit && !psmode_bit && resume_kind == 2'd0); // R10
endmodule

bind stop_ctrl stop_ctrl_chk #(.N_EXT(N_EXT), .N_PER(N_PER)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .nmi_req    (nmi_req),
    .ext_req    (ext_req),
    .ext_mask   (ext_mask),
    .per_req    (per_req),
    .per_mask   (per_mask),
    .osc_en     (osc_en),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .psmode_bit (psmode_bit),
    .stop_bit   (stop_bit),
    .in_stop    (in_stop),
    .wake_pulse (wake_pulse),
    .ready_pulse(ready_pulse),
    .resume_kind(resume_kind)
);

// File: tb/stop_ctrl_test.sv
`timescale 1ns/100ps
module stop_ctrl_test;
    localparam int NE = 7;
    localparam int NP = 4;
    localparam int ED = 5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, wr_en, wr_psmode, wr_stop, nmi_req, isr_active, int_en;
    logic [NE-1:0] ext_req, ext_mask;
    logic [NP-1:0] per_req, per_mask;
    logic [2:0]  pend_lvl, isr_lvl;
    logic [15:0] stab_count;
    logic osc_en, cpu_clk_en, per_clk_en, psmode_bit, stop_bit, in_stop;
    logic wake_pulse, ready_pulse;
    logic [1:0] resume_kind;

    stop_ctrl #(.N_EXT(NE), .N_PER(NP), .LVL_W(3), .CNT_W(16), .ENTRY_DELAY(ED)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_psmode(wr_psmode), .wr_stop(wr_stop),
        .nmi_req(nmi_req), .ext_req(ext_req), .ext_mask(ext_mask),
        .per_req(per_req), .per_mask(per_mask), .pend_lvl(pend_lvl),
        .isr_active(isr_active), .isr_lvl(isr_lvl), .int_en(int_en),
        .stab_count(stab_count), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .psmode_bit(psmode_bit), .stop_bit(stop_bit),
        .in_stop(in_stop), .wake_pulse(wake_pulse), .ready_pulse(ready_pulse),
        .resume_kind(resume_kind)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    task automatic chk(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: phase 0 running, 1 entry window, 2 stopped, 3 settling
    int  m_phase = 3, m_settle = 0, m_window = 0, m_kind = 0;
    bit  m_ps = 0, m_st = 0, m_wp = 0, m_rp = 0;

    function automatic int expected_kind();
        if (nmi_req) return 1;
        if (int_en && (!isr_active || pend_lvl < isr_lvl)) return 1;
        return 2;
    endfunction

    always @(posedge clk) begin
        bit woke;
        bit old_ps, old_st;
        int k;
        woke = nmi_req || ((ext_req & ~ext_mask) != 0) || ((per_req & ~per_mask) != 0);
        k = expected_kind();
        old_ps = m_ps;
        old_st = m_st;
        if (rst) begin
            m_phase = 3; m_settle = int'(stab_count); m_ps = 0; m_st = 0;
            m_kind = 0; m_wp = 0; m_rp = 0;
        end else begin
            m_wp = 0; m_rp = 0;
            if (wr_en) begin m_ps = wr_psmode; m_st = wr_stop; end
            if (m_phase == 0) begin
                if (old_ps && old_st) begin m_phase = 1; m_window = ED - 1; end
            end else if (m_phase == 1) begin
                if (woke) begin m_phase = 0; m_st = 0; end
                else if (m_window == 0) m_phase = 2;
                else m_window--;
            end else if (m_phase == 2) begin
                if (woke) begin
                    m_phase = 3; m_settle = int'(stab_count); m_st = 0; m_wp = 1; m_kind = k;
                end
            end else begin
                if (m_settle == 0) begin m_phase = 0; m_rp = 1; end
                else m_settle--;
            end
        end
    end

    task automatic compare();
        chk("R2", "osc_en", int'(osc_en), int'(m_phase != 2));
        chk("R2", "cpu_clk_en", int'(cpu_clk_en), int'(m_phase <= 1));
        chk("R2", "per_clk_en", int'(per_clk_en), int'(m_phase <= 1));
        chk("R1", "in_stop", int'(in_stop), int'(m_phase == 2));
        chk("R1", "psmode_bit", int'(psmode_bit), int'(m_ps));
        chk("R9", "stop_bit", int'(stop_bit), int'(m_st));
        chk("R4", "wake_pulse", int'(wake_pulse), int'(m_wp));
        chk("R4", "ready_pulse", int'(ready_pulse), int'(m_rp));
        chk("R6", "resume_kind", int'(resume_kind), m_kind);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        compare();
    endtask

    task automatic write_ctl(bit ps, bit st);
        wr_en = 1'b1; wr_psmode = ps; wr_stop = st;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic quiet();
        nmi_req = 1'b0; ext_req = '0; per_req = '0;
        ext_mask = '1; per_mask = '1;
    endtask

    task automatic enter_stop();
        int n = 0;
        write_ctl(1'b1, 1'b1);
        while (!in_stop && n < 100) begin tick(); n++; end
        chk("R1", "edges from write to stop", n, ED + 1);
    endtask

    // Caller has set one wake source; it is applied at the next edge.
    task automatic wake_run(int stab, int exp_kind, string req);
        int n = 0;
        stab_count = 16'(stab);
        tick();
        chk("R5", "left stop at next edge", int'(in_stop), 0);
        chk("R4", "wake pulse", int'(wake_pulse), 1);
        quiet();
        while (!ready_pulse && n < 1000) begin tick(); n++; end
        chk("R4", "settling edges", n, stab + 1);
        chk("R4", "cpu clock back", int'(cpu_clk_en), 1);
        chk(req, "resume kind", int'(resume_kind), exp_kind);
        chk("R9", "stop bit after release", int'(stop_bit), 0);
    endtask

    initial begin
        int n;
        int seen;
        rst = 1'b1; wr_en = 1'b0; wr_psmode = 1'b0; wr_stop = 1'b0;
        int_en = 1'b0; isr_active = 1'b0; pend_lvl = '0; isr_lvl = '0;
        stab_count = 16'd3;
        quiet();
        repeat (3) tick();
        chk("R10", "cpu held in reset", int'(cpu_clk_en), 0);
        rst = 1'b0;
        n = 0;
        while (!cpu_clk_en && n < 1000) begin tick(); n++; end
        chk("R10", "reset settling edges", n, 4);

        // R1: either bit alone does not enter stop
        write_ctl(1'b0, 1'b1);
        seen = 0;
        repeat (20) begin tick(); seen |= int'(in_stop); end
        chk("R1", "stop bit alone", seen, 0);
        write_ctl(1'b1, 1'b0);
        seen = 0;
        repeat (20) begin tick(); seen |= int'(in_stop); end
        chk("R1", "mode bit alone", seen, 0);

        // R3: masked lines keep the block stopped, then a lower-priority line wakes (R7)
        enter_stop();
        ext_req = '1; per_req = '1;
        repeat (10) tick();
        chk("R3", "masked requests ignored", int'(in_stop), 1);
        chk("R3", "oscillator still off", int'(osc_en), 0);
        int_en = 1'b1; isr_active = 1'b1; isr_lvl = 3'd2; pend_lvl = 3'd5;
        tick();
        ext_req = 7'h08; ext_mask = ~7'h08;
        wake_run(2, 2, "R7");

        // R9: no re-entry without a new write
        seen = 0;
        repeat (20) begin tick(); seen |= int'(in_stop); end
        chk("R9", "no re-entry", seen, 0);

        // R7: higher-priority maskable request is acknowledged
        enter_stop();
        int_en = 1'b1; isr_active = 1'b1; isr_lvl = 3'd4; pend_lvl = 3'd1;
        tick();
        ext_req = 7'h01; ext_mask = ~7'h01;
        wake_run(0, 1, "R7");

        // R6: non-maskable wake with interrupts disabled still branches
        enter_stop();
        int_en = 1'b0; isr_active = 1'b1; isr_lvl = 3'd0; pend_lvl = 3'd7;
        tick();
        nmi_req = 1'b1;
        wake_run(7, 1, "R6");

        // R7: peripheral wake with interrupts disabled resumes at next instruction
        enter_stop();
        int_en = 1'b0; isr_active = 1'b0; pend_lvl = 3'd0; isr_lvl = 3'd7;
        tick();
        per_req = 4'b0100; per_mask = 4'b1011;
        wake_run(1, 2, "R7");

        // R7: no handler in service, enabled -> branch
        enter_stop();
        int_en = 1'b1; isr_active = 1'b0; pend_lvl = 3'd6; isr_lvl = 3'd1;
        tick();
        per_req = 4'b0010; per_mask = 4'b1101;
        wake_run(3, 1, "R7");

        // R7: equal priority is not acknowledged
        enter_stop();
        int_en = 1'b1; isr_active = 1'b1; pend_lvl = 3'd3; isr_lvl = 3'd3;
        tick();
        ext_req = 7'h40; ext_mask = ~7'h40;
        wake_run(2, 2, "R7");

        // R8: wake inside the entry window aborts entry
        write_ctl(1'b1, 1'b1);
        tick(); tick();
        chk("R8", "cpu running in window", int'(cpu_clk_en), 1);
        nmi_req = 1'b1;
        tick();
        quiet();
        chk("R8", "stop bit cleared", int'(stop_bit), 0);
        seen = 0;
        repeat (20) begin tick(); seen |= int'(in_stop); end
        chk("R8", "stop never entered", seen, 0);

        // R10: reset while stopped
        enter_stop();
        stab_count = 16'd5;
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R10", "osc on after reset", int'(osc_en), 1);
        chk("R10", "stop bit cleared", int'(stop_bit), 0);
        chk("R10", "mode bit cleared", int'(psmode_bit), 0);
        chk("R10", "resume kind reset", int'(resume_kind), 0);
        n = 0;
        while (!ready_pulse && n < 1000) begin tick(); n++; end
        chk("R10", "settling edges after reset", n, 6);

        repeat (3) tick();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 50000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule